// File: doc/BRIEF.md
# Parallel Binary-to-Residue Converter

This block takes an unsigned binary word of `NSEG*SEG_W` bits and returns its residue for the modulus `2^SEG_W - KVAL` or `2^SEG_W + KVAL`. The parameter `PLUS_MOD` selects between them. The word is cut into `NSEG` slices of `SEG_W` bits. Each slice is scaled by a weight and reduced on its own. The weight is the matching power of the modulus offset, folded into range at elaboration. The reduced terms are then summed and brought into range once more. No lookup table is used; every weight is computed as a constant.

For the plus modulus, odd-numbered powers of the offset carry a negative sign. Each odd slice is inverted bit by bit and multiplied by its positive weight. A single elaboration-time correction constant joins the final sum and restores the missing part. A sample arrives with a one-cycle valid strobe. Its residue appears on a registered output exactly two clock edges later. One sample is accepted every cycle.

Top module: `rns_fwd_conv`

## Requirements
- R1: With `PLUS_MOD=0`, `outRes` equals the input value modulo `2^SEG_W-KVAL`, where slice i is bits `[(i+1)*SEG_W-1 : i*SEG_W]` of `inData`.
- R2: With `PLUS_MOD=1`, `outRes` equals the input value modulo `2^SEG_W+KVAL`.
- R3: A delivered residue always lies in `[0, modulus-1]`. `outRes` is `SEG_W` bits wide for the minus modulus and `SEG_W+1` bits wide for the plus modulus.
- R4: A sample presented with `inValid=1` at a rising edge yields `outValid=1` and its residue after the second following rising edge. Samples on consecutive cycles each give their own result in order.
- R5: `outValid` is 0 in every cycle that does not follow an accepted sample by exactly two edges.
- R6: While `rst` is high, `outValid` is cleared at the next edge.
- R7: The all-zero input gives residue 0. The all-ones input gives `(2^(NSEG*SEG_W)-1)` modulo the modulus.
- R8: While `outValid` is 0, `outRes` keeps the last delivered residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample strobe |
| inData | input | NSEG*SEG_W | Unsigned binary sample |
| outValid | output | 1 | Residue strobe |
| outRes | output | SEG_W+PLUS_MOD | Residue of the sample |

## Verification
Two configurations are tried: four 8-bit slices against modulus 253, and eight 6-bit slices against modulus 69 with the odd-slice negation. Pseudo-random words exercise every slice weight at once. Single-slice words isolate one weight and its sign. All-ones words, and words with every slice at its maximum, push the largest sums through both reductions. Values just below and at the modulus expose any off-by-one in the final subtraction. Back-to-back bursts, idle gaps and a mid-run reset separate the pipeline timing from the arithmetic.

// File: rtl/rns_fwd_pkg.sv
package rns_fwd_pkg;

  typedef struct packed {
    logic loadTerms;
    logic loadRes;
  } stageStrobe_t;

  function automatic longint unsigned modValue(int n, int k, bit plus);
    return plus ? ((64'd1 << n) + 64'(k)) : ((64'd1 << n) - 64'(k));
  endfunction

  // weight of slice i: k^i folded below the modulus (sign handled by datapath)
  function automatic longint unsigned sliceWeight(int i, int n, int k, bit plus);
    longint unsigned m, w;
    m = modValue(n, k, plus);
    w = 64'd1 % m;
    for (int e = 0; e < i; e++) w = (w * 64'(k)) % m;
    return w;
  endfunction

  // sum over odd slices of weight*(k+1), reduced; zero for the minus modulus
  function automatic longint unsigned corrValue(int j, int n, int k, bit plus);
    longint unsigned m, c;
    m = modValue(n, k, plus);
    c = 0;
    if (plus)
      for (int i = 1; i < j; i += 2)
        c = (c + sliceWeight(i, n, k, plus) * 64'(k + 1)) % m;
    return c;
  endfunction

endpackage

// File: rtl/rns_fwd_ctrl.sv
module rns_fwd_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  output rns_fwd_pkg::stageStrobe_t strobe,
  output logic outValid
);
  logic termValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      termValid <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      termValid <= inValid;
      outValid  <= termValid;
    end
  end

  always_comb begin
    strobe.loadTerms = inValid;
    strobe.loadRes   = termValid;
  end
endmodule

// File: rtl/rns_fwd_dp.sv
module rns_fwd_dp #(
  parameter int SEG_W    = 8,
  parameter int KVAL     = 3,
  parameter int NSEG     = 4,
  parameter int PLUS_MOD = 0
) (
  input  logic clk,
  input  rns_fwd_pkg::stageStrobe_t strobe,
  input  logic [SEG_W*NSEG-1:0] inData,
  output logic [SEG_W+PLUS_MOD-1:0] outRes
);
  localparam int RW  = SEG_W + PLUS_MOD;
  localparam int PW  = SEG_W + RW;
  localparam int SW  = RW + $clog2(NSEG + 1);
  localparam int LW  = (PW > SW) ? PW : SW;
  localparam int XW  = LW + RW + 1;
  localparam longint unsigned MODV = rns_fwd_pkg::modValue(SEG_W, KVAL, PLUS_MOD != 0);
  localparam logic [RW-1:0] CORR = RW'(rns_fwd_pkg::corrValue(NSEG, SEG_W, KVAL, PLUS_MOD != 0));

  // compare-and-subtract reduction by shifted copies of the modulus
  function automatic logic [RW-1:0] reduceMod(input logic [LW-1:0] v);
    logic [XW-1:0] t, m;
    t = XW'(v);
    for (int s = LW - 1; s >= 0; s--) begin
      m = XW'(MODV) << s;
      if (t >= m) t = t - m;
    end
    return t[RW-1:0];
  endfunction

  logic [RW-1:0] termReg [NSEG];
  logic [RW-1:0] termNext [NSEG];

  // stage 1: per-slice modular constant products
  for (genvar i = 0; i < NSEG; i++) begin : g_slice
    localparam logic [RW-1:0] WGT =
      RW'(rns_fwd_pkg::sliceWeight(i, SEG_W, KVAL, PLUS_MOD != 0));
    localparam bit NEG = (PLUS_MOD != 0) && (i % 2 == 1);
    logic [SEG_W-1:0] seg;
    logic [PW-1:0] prod;
    always_comb begin
      seg  = inData[i*SEG_W +: SEG_W];
      if (NEG) seg = ~seg;
      prod = PW'(seg) * PW'(WGT);
      termNext[i] = reduceMod(LW'(prod));
    end
    always_ff @(posedge clk)
      if (strobe.loadTerms) termReg[i] <= termNext[i];
  end

  // stage 2: add reduced terms and correction, final reduction
  logic [SW-1:0] partial [NSEG+1];
  assign partial[0] = SW'(CORR);
  for (genvar i = 0; i < NSEG; i++) begin : g_acc
    assign partial[i+1] = partial[i] + SW'(termReg[i]);
  end

  always_ff @(posedge clk)
    if (strobe.loadRes) outRes <= reduceMod(LW'(partial[NSEG]));
endmodule

// File: rtl/rns_fwd_conv.sv
module rns_fwd_conv #(
  parameter int SEG_W    = 8,
  parameter int KVAL     = 3,
  parameter int NSEG     = 4,
  parameter int PLUS_MOD = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  input  logic [SEG_W*NSEG-1:0] inData,
  output logic outValid,
  output logic [SEG_W+PLUS_MOD-1:0] outRes
);
  rns_fwd_pkg::stageStrobe_t strobe;

  rns_fwd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  rns_fwd_dp #(.SEG_W(SEG_W), .KVAL(KVAL), .NSEG(NSEG), .PLUS_MOD(PLUS_MOD)) u_dp (
    .clk(clk), .strobe(strobe), .inData(inData), .outRes(outRes)
  );
endmodule

// File: rtl/rns_fwd_conv_chk.sv
module rns_fwd_conv_chk #(
  parameter int SEG_W    = 8,
  parameter int KVAL     = 3,
  parameter int NSEG     = 4,
  parameter int PLUS_MOD = 0
) (
  input logic clk,
  input logic rst,
  input logic inValid,
  input logic outValid,
  input logic [SEG_W+PLUS_MOD-1:0] outRes
);
  localparam int RW = SEG_W + PLUS_MOD;
  localparam logic [RW:0] MODV = (RW+1)'(rns_fwd_pkg::modValue(SEG_W, KVAL, PLUS_MOD != 0));

  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##2 outValid);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> ##2 !outValid);
  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ({1'b0, outRes} < MODV));
  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> !outValid);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!outValid && !$past(rst)) |-> $stable(outRes));
endmodule

bind rns_fwd_conv rns_fwd_conv_chk #(
  .SEG_W(SEG_W), .KVAL(KVAL), .NSEG(NSEG), .PLUS_MOD(PLUS_MOD)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .outValid(outValid), .outRes(outRes)
);

// File: tb/tb_rns_fwd_conv.sv
`timescale 1ns/1ps
module tb_rns_fwd_conv;
  localparam int AN = 8, AK = 3, AJ = 4;
  localparam int PN = 6, PK = 5, PJ = 8;
  localparam int AW = AN*AJ, PW = PN*PJ;
  localparam longint unsigned AMOD = (64'd1 << AN) - AK;
  localparam longint unsigned PMOD = (64'd1 << PN) + PK;

  logic clk = 0;
  logic rst = 1;
  logic aValid = 0, pValid = 0;
  logic [AW-1:0] aData = '0;
  logic [PW-1:0] pData = '0;
  logic aOutValid, pOutValid;
  logic [AN-1:0] aRes;
  logic [PN:0] pRes;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rns_fwd_conv #(.SEG_W(AN), .KVAL(AK), .NSEG(AJ), .PLUS_MOD(0)) dut (
    .clk(clk), .rst(rst), .inValid(aValid), .inData(aData),
    .outValid(aOutValid), .outRes(aRes));

  rns_fwd_conv #(.SEG_W(PN), .KVAL(PK), .NSEG(PJ), .PLUS_MOD(1)) dutP (
    .clk(clk), .rst(rst), .inValid(pValid), .inData(pData),
    .outValid(pOutValid), .outRes(pRes));

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sample through both converters, checked two edges later
  task automatic runPair(input logic [AW-1:0] a, input logic [PW-1:0] p, input string reqA, input string reqP);
    @(negedge clk);
    aValid = 1; aData = a; pValid = 1; pData = p;
    @(negedge clk);
    aValid = 0; pValid = 0;
    @(negedge clk);
    check({reqA, " valid"}, 64'(aOutValid), 1);
    check(reqA, 64'(aRes), 64'(a) % AMOD);
    check({reqP, " valid"}, 64'(pOutValid), 1);
    check(reqP, 64'(pRes), 64'(p) % PMOD);
  endtask

  initial begin
    #(8*150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] lcg;
    logic [AN-1:0] held;
    logic [AW-1:0] burst [8];
    repeat (3) @(negedge clk);
    check("R6 reset outValid A", 64'(aOutValid), 0);
    check("R6 reset outValid P", 64'(pOutValid), 0);
    rst = 0;

    // R7 extremes
    runPair('0, '0, "R7 zero A", "R7 zero P");
    runPair('1, '1, "R7 ones A", "R7 ones P");
    // boundaries near the modulus
    runPair(AW'(AMOD), PW'(PMOD), "R3 at mod A", "R3 at mod P");
    runPair(AW'(AMOD-1), PW'(PMOD-1), "R3 mod-1 A", "R3 mod-1 P");
    // single slices at maximum: isolates each weight and sign
    for (int i = 0; i < PJ; i++)
      runPair(AW'({AN{1'b1}}) << ((i % AJ)*AN), PW'({PN{1'b1}}) << (i*PN),
              "R1 single slice", "R2 single slice");
    // all slices at mod-1 style maximum
    for (int v = 0; v < 4; v++)
      runPair({AJ{AN'(AMOD-1-v)}}, {PJ{PN'(63-v)}}, "R1 max slices", "R2 max slices");
    // pseudo-random sweep
    lcg = 64'h1234_5678_9abc_def1;
    for (int n = 0; n < 3000; n++) begin
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      runPair(lcg[63:32], lcg[59:12], "R1 random", "R2 random");
    end

    // R4 back-to-back burst on A
    for (int i = 0; i < 8; i++) burst[i] = AW'(32'h9e37_79b9 * (i + 1));
    for (int idx = 0; idx < 10; idx++) begin
      @(negedge clk);
      if (idx >= 2) begin
        check("R4 burst valid", 64'(aOutValid), 1);
        check("R4 burst order", 64'(aRes), 64'(burst[idx-2]) % AMOD);
      end
      aValid = (idx < 8);
      aData  = (idx < 8) ? burst[idx] : '0;
    end
    aValid = 0;

    // R5 and R8 idle: no strobe, residue held
    @(negedge clk);
    held = aRes;
    repeat (3) begin
      @(negedge clk);
      check("R5 idle valid A", 64'(aOutValid), 0);
      check("R8 held residue", 64'(aRes), 64'(held));
    end

    // R6 reset while a sample is in flight
    @(negedge clk);
    aValid = 1; aData = 32'h0bad_f00d;
    @(negedge clk);
    aValid = 0; rst = 1;
    @(negedge clk);
    check("R6 reset in flight", 64'(aOutValid), 0);
    rst = 0;
    @(negedge clk);
    check("R6 after reset", 64'(aOutValid), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule